// File: doc/BRIEF.md
# MII Management Serial Target

This block is a management-interface target. It is driven one bit at a time through a single host control word, with no real clock or data pins. Each host write is a beat. A beat carries a management-clock flag, direction flags and one data bit. Beats with the write pattern feed one bit into a frame decoder. The decoder finds the start sequence, decodes the opcode and collects a 5-bit PHY address and a 5-bit register address. It then either loads a register value for reading back or takes 16 data bits and stores them.

Beats with the read pattern return data one bit per beat from a 32-bit output shift register. The block holds 32 registers of 16 bits for one PHY address, chosen by parameter. Register 1 never returns its stored value. It returns a synthesised link status taken from an input pin.

The host write path is a valid-only stream: every beat with `host_valid` high is taken in that cycle. There is no back-pressure, so no ready signal exists. The control word seen by the host, `ctrl_out`, is registered and changes on the clock edge that takes a beat.

Top module: `mii_mgmt_target`

## Requirements
- R1: Control word fields are: bit 19 is the bit returned to the host, bit 18 is MII-read select, bit 17 is the host data bit, bit 16 is the management clock, bit 14 is the read-operation flag and bit 13 is the write-operation flag. With bit 17 masked off, a word equal to 0x00054000 is a read strobe and a word equal to 0x00012000 is a write strobe. A write strobe carries bit 17 as its data bit.
- R2: A beat that is neither strobe leaves the decoder and the output shift register unchanged, even in the middle of a frame.
- R3: In idle, any number of 1 bits are ignored. A 0 followed by a 1 forms the start sequence. A 0 followed by a 0 returns to idle.
- R4: After the start sequence, the opcode 1,0 selects read and 0,1 selects write. The pairs 1,1 and 0,0 abandon the frame.
- R5: A frame then carries 5 PHY-address bits and 5 register-address bits, both MSB first.
- R6: For a read, the 16-bit value is loaded at bits 30..15 of the output shift register, with bit 31 cleared. The first read strobe therefore returns 0 (a dummy bit), the next 16 return the value MSB first, and later strobes return 0.
- R7: A read strobe sets `ctrl_out` to the written word with bit 19 replaced by bit 31 of the output shift register, then shifts that register left by one. Any other beat copies the written word into `ctrl_out` unchanged.
- R8: A write frame needs the turnaround bits 1 then 0 after the register address. Any other turnaround abandons the frame and stores nothing.
- R9: A write frame then takes 16 data bits MSB first and stores them after the 16th bit.
- R10: A read of register 1 returns 0x0004 when `link_present` is high and 0x0000 when it is low, whatever was written there.
- R11: Reads from a PHY address other than `OWN_PHY` return 0xFFFF. Writes to another PHY address store nothing.
- R12: Synchronous active-high reset returns the decoder to idle and clears `ctrl_out`, the output shift register and all stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_present | input | 1 | Link status reported through register 1 |
| host_valid | input | 1 | Host beat valid; always accepted |
| host_word | input | 32 | Control word written by the host |
| ctrl_out | output | 32 | Registered control word as seen by the host |

## Verification
The bench builds the block with `OWN_PHY` set to 19 rather than the default 0. A nonzero address with mixed bit values exposes a PHY address shifted in the wrong order or lost. It also makes foreign-address frames, which differ from 19 in varied bit positions, exercise the ignore and 0xFFFF paths. Random frames use random preamble lengths and have unrelated beats mixed in mid-frame. Directed frames cover register 0, register 31, register 1 under both link states, every abandoned opcode and turnaround, and a reset that arrives mid-frame.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int CTRL_W = 32;
  localparam int B_DIN  = 19;
  localparam int B_MRD  = 18;
  localparam int B_DOUT = 17;
  localparam int B_MCLK = 16;
  localparam int B_RDOP = 14;
  localparam int B_WROP = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_START, ST_OP_RD, ST_OP_WR,
    ST_PHY, ST_REG, ST_TA_HI, ST_TA_LO, ST_DATA
  } dec_state_e;
endpackage

// File: rtl/mii_strobe_class.sv
module mii_strobe_class
  import mii_mgmt_pkg::*;
(
  input  logic              valid,
  input  logic [CTRL_W-1:0] word,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              bit_in
);
  localparam logic [CTRL_W-1:0] RD_PAT = (CTRL_W'(1) << B_MRD) | (CTRL_W'(1) << B_RDOP) | (CTRL_W'(1) << B_MCLK);
  localparam logic [CTRL_W-1:0] WR_PAT = (CTRL_W'(1) << B_WROP) | (CTRL_W'(1) << B_MCLK);
  localparam logic [CTRL_W-1:0] MASK   = ~(CTRL_W'(1) << B_DOUT);

  logic [CTRL_W-1:0] masked;
  assign masked = word & MASK;
  assign rd_stb = valid && (masked == RD_PAT);
  assign wr_stb = valid && (masked == WR_PAT);
  assign bit_in = word[B_DOUT];
endmodule

// File: rtl/mii_frame_dec.sv
module mii_frame_dec
  import mii_mgmt_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic          bit_in,
  output logic [3:0]    state_o,
  output logic          rd_go,
  output logic          wr_go,
  output logic [AW-1:0] phy_o,
  output logic [AW-1:0] rga_o,
  output logic [DW-1:0] dat_o
);
  localparam int CNT_W = $clog2(DW) + 1;

  dec_state_e    st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [AW-1:0] phy, phy_n, rga, rga_n;
  logic [DW-1:0] dat, dat_n;
  logic          is_rd, is_rd_n;

  always_comb begin
    st_n = st; cnt_n = cnt; phy_n = phy; rga_n = rga; dat_n = dat; is_rd_n = is_rd;
    rd_go = 1'b0; wr_go = 1'b0;
    if (bit_valid) begin
      unique case (st)
        ST_IDLE: begin
          phy_n = '0; rga_n = '0; dat_n = '0;
          if (!bit_in) st_n = ST_SYNC;
        end
        ST_SYNC:  st_n = bit_in ? ST_START : ST_IDLE;
        ST_START: st_n = bit_in ? ST_OP_RD : ST_OP_WR;
        ST_OP_RD: begin st_n = bit_in ? ST_IDLE : ST_PHY; is_rd_n = 1'b1; cnt_n = '0; end
        ST_OP_WR: begin st_n = bit_in ? ST_PHY : ST_IDLE; is_rd_n = 1'b0; cnt_n = '0; end
        ST_PHY: begin
          phy_n = {phy[AW-2:0], bit_in};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(AW-1)) begin st_n = ST_REG; cnt_n = '0; end
        end
        ST_REG: begin
          rga_n = {rga[AW-2:0], bit_in};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(AW-1)) begin
            cnt_n = '0;
            if (is_rd) begin rd_go = 1'b1; st_n = ST_IDLE; end
            else st_n = ST_TA_HI;
          end
        end
        ST_TA_HI: st_n = bit_in ? ST_TA_LO : ST_IDLE;
        ST_TA_LO: begin st_n = bit_in ? ST_IDLE : ST_DATA; cnt_n = '0; end
        ST_DATA: begin
          dat_n = {dat[DW-2:0], bit_in};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(DW-1)) begin wr_go = 1'b1; st_n = ST_IDLE; end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; phy <= '0; rga <= '0; dat <= '0; is_rd <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; phy <= phy_n; rga <= rga_n; dat <= dat_n; is_rd <= is_rd_n;
    end
  end

  assign state_o = st;
  assign phy_o   = phy_n;
  assign rga_o   = rga_n;
  assign dat_o   = dat_n;
endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs #(
  parameter int            AW      = 5,
  parameter int            DW      = 16,
  parameter logic [AW-1:0] OWN_PHY = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_present,
  input  logic          wr_go,
  input  logic [AW-1:0] phy,
  input  logic [AW-1:0] rga,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int            NREG     = 1 << AW;
  localparam logic [AW-1:0] STAT_REG = AW'(1);
  localparam logic [DW-1:0] LINK_UP  = DW'(4);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_go && phy == OWN_PHY) begin
      mem[rga] <= wdata;
    end
  end

  always_comb begin
    if (phy != OWN_PHY)      rdata = '1;
    else if (rga == STAT_REG) rdata = link_present ? LINK_UP : '0;
    else                      rdata = mem[rga];
  end
endmodule

// File: rtl/mii_out_shift.sv
module mii_out_shift #(
  parameter int CW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  output logic [CW-1:0] sh
);
  localparam int OFF = CW - 1 - DW;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= CW'(load_val) << OFF;
    else if (shift) sh <= sh << 1;
  end
endmodule

// File: rtl/mii_mgmt_target.sv
module mii_mgmt_target
  import mii_mgmt_pkg::*;
#(
  parameter int             AW      = 5,
  parameter int             DW      = 16,
  parameter logic [AW-1:0]  OWN_PHY = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_present,
  input  logic              host_valid,
  input  logic [CTRL_W-1:0] host_word,
  output logic [CTRL_W-1:0] ctrl_out
);
  logic          rd_stb, wr_stb, bit_in;
  logic [3:0]    dec_state;
  logic          rd_go, wr_go;
  logic [AW-1:0] phy, rga;
  logic [DW-1:0] wdat, rdat;
  logic [CTRL_W-1:0] shreg, ctrl_q;

  mii_strobe_class u_cls (
    .valid(host_valid), .word(host_word),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bit_in(bit_in)
  );

  mii_frame_dec #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .bit_valid(wr_stb), .bit_in(bit_in),
    .state_o(dec_state), .rd_go(rd_go), .wr_go(wr_go),
    .phy_o(phy), .rga_o(rga), .dat_o(wdat)
  );

  mii_phy_regs #(.AW(AW), .DW(DW), .OWN_PHY(OWN_PHY)) u_regs (
    .clk(clk), .rst(rst), .link_present(link_present), .wr_go(wr_go),
    .phy(phy), .rga(rga), .wdata(wdat), .rdata(rdat)
  );

  mii_out_shift #(.CW(CTRL_W), .DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(rd_go), .load_val(rdat),
    .shift(rd_stb), .sh(shreg)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (host_valid) begin
      ctrl_q <= host_word;
      if (rd_stb) ctrl_q[B_DIN] <= shreg[CTRL_W-1];
    end
  end

  assign ctrl_out = ctrl_q;
endmodule

// File: rtl/mii_mgmt_target_chk.sv
module mii_mgmt_target_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          host_valid,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [3:0]    dec_state,
  input logic [CW-1:0] shreg,
  input logic [CW-1:0] ctrl_out
);
  a_r7_din_copy: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> ctrl_out[19] == $past(shreg[CW-1]));

  a_r7_shift_left: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> shreg == ($past(shreg) << 1));

  a_r2_other_beat_holds: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !rd_stb && !wr_stb) |=> ($stable(dec_state) && $stable(shreg)));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !host_valid |=> ($stable(ctrl_out) && $stable(shreg) && $stable(dec_state)));

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (dec_state == 4'd0 && shreg == '0 && ctrl_out == '0));
endmodule

bind mii_mgmt_target mii_mgmt_target_chk #(.CW(mii_mgmt_pkg::CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .dec_state(dec_state), .shreg(shreg), .ctrl_out(ctrl_out)
);

// File: tb/mii_mgmt_target_tb.sv
`timescale 1ns/1ps
module mii_mgmt_target_tb;
  localparam logic [4:0] OWN = 5'd19;
  localparam logic [31:0] WR_BASE = 32'h0001_2000;
  localparam logic [31:0] RD_BASE = 32'h0005_4000;

  logic clk = 0, rst = 1, link_present = 0, host_valid = 0;
  logic [31:0] host_word = '0;
  logic [31:0] ctrl_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit junk_en = 0;
  logic [15:0] model [32];

  always #2 clk = ~clk;

  mii_mgmt_target #(.OWN_PHY(OWN)) u_dut (
    .clk(clk), .rst(rst), .link_present(link_present),
    .host_valid(host_valid), .host_word(host_word), .ctrl_out(ctrl_out)
  );

  function automatic logic [15:0] exp_read(logic [4:0] p, logic [4:0] r);
    if (p != OWN) return 16'hFFFF;
    if (r == 5'd1) return link_present ? 16'h0004 : 16'h0000;
    return model[r];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_put(logic [31:0] w);
    @(negedge clk); host_valid = 1; host_word = w;
    @(negedge clk); host_valid = 0;
  endtask

  task automatic junk();
    logic [31:0] w;
    w = $urandom() & ~32'h0001_0000;
    host_put(w);
    check("R7 plain beat copy", ctrl_out, w);
  endtask

  task automatic send_bit(bit b);
    if (junk_en && ($urandom() % 8 == 0)) junk();
    host_put(WR_BASE | (32'(b) << 17));
  endtask

  task automatic send_field(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic preamble(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic mdio_write(logic [4:0] p, logic [4:0] r, logic [15:0] d, int pre);
    preamble(pre);
    send_field(16'b0101, 4);
    send_field(16'(p), 5); send_field(16'(r), 5);
    send_field(16'b10, 2);
    send_field(d, 16);
    if (p == OWN) model[r] = d;
  endtask

  task automatic mdio_read(string req, logic [4:0] p, logic [4:0] r, int pre);
    logic [17:0] got;
    logic [15:0] e;
    preamble(pre);
    send_field(16'b0110, 4);
    send_field(16'(p), 5); send_field(16'(r), 5);
    e = exp_read(p, r);
    got = '0;
    for (int i = 0; i < 18; i++) begin
      host_put(RD_BASE | (32'($urandom() & 1) << 17));
      got = {got[16:0], ctrl_out[19]};
    end
    check(req, 32'(got), 32'({1'b0, e, 1'b0}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R12 ctrl_out after reset", ctrl_out, 32'h0);
    mdio_read("R12 regs cleared", OWN, 5'd5, 0);

    // R10 link status
    link_present = 1;
    mdio_read("R10 link up", OWN, 5'd1, 2);
    mdio_write(OWN, 5'd1, 16'h1234, 1);
    mdio_read("R10 stored value hidden", OWN, 5'd1, 0);
    link_present = 0;
    mdio_read("R10 link down", OWN, 5'd1, 3);

    // R5 R9 boundary registers
    mdio_write(OWN, 5'd0, 16'hA5C3, 32);
    mdio_write(OWN, 5'd31, 16'h8001, 0);
    mdio_read("R5 R9 reg 0", OWN, 5'd0, 0);
    mdio_read("R5 R9 reg 31 and R6 dummy/trailing", OWN, 5'd31, 5);

    // R11 foreign PHY
    mdio_write(5'd3, 5'd0, 16'h0BAD, 1);
    mdio_read("R11 foreign read", 5'd3, 5'd0, 0);
    mdio_read("R11 foreign write ignored", OWN, 5'd0, 0);

    // R3 aborted start 0,0 then frame with no preamble
    send_bit(0); send_bit(0);
    mdio_write(OWN, 5'd9, 16'h3C3C, 0);
    mdio_read("R3 restart after 0,0", OWN, 5'd9, 0);

    // R4 bad opcodes
    send_field(16'b0111, 4); preamble(40);
    mdio_read("R4 opcode 11 abandoned", OWN, 5'd31, 0);
    send_field(16'b0100, 4); preamble(40);
    mdio_read("R4 opcode 00 abandoned", OWN, 5'd31, 0);

    // R8 bad turnaround
    send_field(16'b0101, 4); send_field(16'(OWN), 5); send_field(16'd7, 5);
    send_field(16'b11, 2); send_field(16'hFFFF, 16);
    mdio_read("R8 turnaround 11", OWN, 5'd7, 0);
    send_field(16'b0101, 4); send_field(16'(OWN), 5); send_field(16'd7, 5);
    send_field(16'b00, 2); send_field(16'hFFFF, 16);
    mdio_read("R8 turnaround 00", OWN, 5'd7, 0);

    // R1 R2 R7 with unrelated beats mixed in
    junk_en = 1;
    for (int k = 0; k < 60; k++) begin
      logic [4:0] p, r;
      p = ($urandom() % 4 == 0) ? 5'($urandom()) : OWN;
      r = 5'($urandom());
      link_present = 1'($urandom());
      if ($urandom() % 2) mdio_write(p, r, 16'($urandom()), $urandom() % 6);
      else mdio_read("R1 R2 random read", p, r, $urandom() % 6);
    end
    junk_en = 0;

    // R12 reset mid-frame
    mdio_write(OWN, 5'd12, 16'h7777, 0);
    send_field(16'b0101, 4); send_field(16'(OWN), 3);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    check("R12 ctrl_out cleared", ctrl_out, 32'h0);
    mdio_read("R12 reg cleared", OWN, 5'd12, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule